// File: doc/BRIEF.md
# Prescaled PWM and Capture Timer

This block is a 16-bit timer with four operating modes selected by one control word: pulse-width modulation, input pulse capture, a plain periodic or one-shot timer, and external event counting. The count rate comes from a power-of-two prescaler. Two 16-bit match registers, named Rise and Fall, set when the PWM output goes high and low. The Fall register also sets the terminal count for the timer and event modes.

Software writes Rise and Fall into shadow copies. The counter only uses these values after they are copied into the active registers. A control write copies them and restarts the timer. While the timer runs, the copy happens each time the counter wraps, so a pulse train never mixes old and new settings within one cycle.

In capture mode the timer works the other way round. Edges on the capture pin store the running count into the active Rise and Fall registers. Reading either of them freezes the counter, so the software sees a consistent pair of timestamps.

Top module: `pwm_cap_timer`

## Requirements
- R1: Register map by address: 0 = control, 1 = Rise, 2 = Fall, 3 = count. Reads of Rise and Fall return the active values. Control bits: [4:0] prescale P; [6:5] mode (0 PWM, 1 capture, 2 timer, 3 event); [7] single-shot; [8] gate enable; [10:9] edge select (bit 9 rising, bit 10 falling); [11] output enable; [12] run; [13] Rise interrupt enable; [14] Fall interrupt enable. After reset every register reads 0 and all outputs are low.
- R2: In PWM, timer and capture modes the counter advances once every 2^P clock cycles; P = 0 advances it every cycle. A control write clears the prescaler and the counter.
- R3: In PWM and timer modes with gate enable set, the counter holds its value while the gate/event pin is high (after a two-flop synchronizer) and resumes when the pin goes low.
- R4: In continuous PWM and timer modes the counter runs 0..Fall and then wraps to 0, giving a period of Fall+1 counts. The PWM level goes high when the count reaches Rise and low when it reaches Fall.
- R5: Rise and Fall writes change only the shadow copies. The active values, as seen by a read, change on the next wrap or on a control write.
- R6: In single-shot mode, reaching Fall clears the run bit, holds the count at Fall, raises one Fall interrupt, and leaves the PWM level low.
- R7: In capture mode the counter advances from 0. Each synchronized rising edge on the capture pin stores the count in Rise, and each falling edge stores it in Fall, so only the last pulse is kept. With P = 0, Fall minus Rise equals the pulse width in clock cycles.
- R8: In capture mode a read of Rise or Fall clears the run bit and freezes the count. A read of the count register does not.
- R9: In event mode the counter advances once per synchronized edge of the selected polarity on the gate/event pin. Edges of the other polarity are ignored. Reaching Fall raises the Fall interrupt.
- R10: irq_rise_o and irq_fall_o pulse for one cycle when the count reaches Rise or Fall, and only if the matching enable bit is set.
- R11: pwm_o is low unless the mode is PWM and the output enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_en_i | input | 1 | Register read strobe (side effect in capture mode) |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 16 | Register read data, combinational |
| gate_i | input | 1 | Gate input or event input, asynchronous |
| cap_i | input | 1 | Capture input, asynchronous |
| pwm_o | output | 1 | PWM output |
| irq_rise_o | output | 1 | Rise match interrupt pulse |
| irq_fall_o | output | 1 | Fall match interrupt pulse |

## Verification
The hardest case to reach is the shadow handover. A new Fall value has to be written while a cycle is in flight, but early enough that the read-back still shows the old active value. The stimulus waits for a Fall interrupt, so the counter is known to sit at Fall and wrap on the next count. The write and the read then land at known counts. The bench then measures the gap between interrupts and expects one period with the old length, followed by the new period. Capture timestamps pass through a synchronizer of fixed latency, so the bench checks the difference between Rise and Fall rather than their absolute values.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int PRE_W  = 5;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_RISE  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_FALL  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd3;

    typedef enum logic [1:0] {
        MODE_PWM = 2'd0,
        MODE_CAP = 2'd1,
        MODE_TMR = 2'd2,
        MODE_EVT = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic             irq_fall_en;
        logic             irq_rise_en;
        logic             run;
        logic             out_en;
        logic [1:0]       edge_sel;
        logic             gate_en;
        logic             single;
        tmr_mode_e        mode;
        logic [PRE_W-1:0] prescale;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    // sh_q[STAGES-1] is the synchronized level; sh_q[STAGES] is its previous value
    assign lvl_o  = sh_q[STAGES-1];
    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int PRE_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic [PRE_W-1:0] shift_i,
    output logic             tick_o
);

    localparam int DIV_W = 2 ** PRE_W;

    logic [DIV_W-1:0] div_q, div_d;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit  = (DIV_W'(1) << shift_i) - DIV_W'(1);
        tick_o = en_i && !clr_i && (div_q == limit);
        if (clr_i || !en_i || tick_o) div_d = '0;
        else                          div_d = div_q + DIV_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
    end

    // with a divider above one, two ticks never come back to back
    p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && shift_i != '0 && !clr_i) |=> !tick_o);

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [CNT_W-1:0]  rd_data_o,
    input  logic              tick_i,
    input  logic              gate_lvl_i,
    input  logic              evt_rise_i,
    input  logic              evt_fall_i,
    input  logic              cap_rise_i,
    input  logic              cap_fall_i,
    output logic              pre_en_o,
    output logic              pre_clr_o,
    output logic [PRE_W-1:0]  prescale_o,
    output logic              pwm_o,
    output logic              irq_rise_o,
    output logic              irq_fall_o
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rise_a;
        logic [CNT_W-1:0] fall_a;
        logic [CNT_W-1:0] rise_s;
        logic [CNT_W-1:0] fall_s;
        logic             pwm;
        logic             irq_r;
        logic             irq_f;
    } state_t;

    state_t           s_q, s_d;
    logic             ctl_wr;
    logic             adv;
    logic             cap_rd;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        ctl_wr = wr_en_i && (wr_addr_i == ADDR_CTRL);
        cap_rd = rd_en_i && ((rd_addr_i == ADDR_RISE) || (rd_addr_i == ADDR_FALL));

        case (s_q.ctrl.mode)
            MODE_PWM, MODE_TMR: adv = tick_i && !(s_q.ctrl.gate_en && gate_lvl_i);
            MODE_CAP:           adv = tick_i;
            default:            adv = s_q.ctrl.run &&
                                      ((s_q.ctrl.edge_sel[0] && evt_rise_i) ||
                                       (s_q.ctrl.edge_sel[1] && evt_fall_i));
        endcase

        s_d       = s_q;
        s_d.irq_r = 1'b0;
        s_d.irq_f = 1'b0;
        nxt       = s_q.cnt;

        if (wr_en_i && wr_addr_i == ADDR_RISE) s_d.rise_s = wr_data_i;
        if (wr_en_i && wr_addr_i == ADDR_FALL) s_d.fall_s = wr_data_i;

        if (ctl_wr) begin
            s_d.ctrl   = ctrl_t'(wr_data_i[CTRL_W-1:0]);
            s_d.cnt    = '0;
            s_d.pwm    = 1'b0;
            s_d.rise_a = s_q.rise_s;
            s_d.fall_a = s_q.fall_s;
        end else if (s_q.ctrl.mode == MODE_CAP) begin
            if (adv) s_d.cnt = s_q.cnt + CNT_W'(1);
            if (s_q.ctrl.run && cap_rise_i) s_d.rise_a = s_q.cnt;
            if (s_q.ctrl.run && cap_fall_i) s_d.fall_a = s_q.cnt;
            if (cap_rd) s_d.ctrl.run = 1'b0;
        end else if (adv) begin
            if (s_q.cnt == s_q.fall_a) begin
                nxt        = '0;
                s_d.rise_a = s_q.rise_s;
                s_d.fall_a = s_q.fall_s;
            end else begin
                nxt = s_q.cnt + CNT_W'(1);
            end
            s_d.cnt = nxt;
            if (nxt == s_d.fall_a) begin
                s_d.pwm   = 1'b0;
                s_d.irq_f = s_q.ctrl.irq_fall_en;
                if (s_q.ctrl.single) s_d.ctrl.run = 1'b0;
            end else if (nxt == s_d.rise_a) begin
                s_d.pwm   = 1'b1;
                s_d.irq_r = s_q.ctrl.irq_rise_en;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    always_comb begin
        case (rd_addr_i)
            ADDR_CTRL: rd_data_o = CNT_W'(s_q.ctrl);
            ADDR_RISE: rd_data_o = s_q.rise_a;
            ADDR_FALL: rd_data_o = s_q.fall_a;
            default:   rd_data_o = s_q.cnt;
        endcase
    end

    assign pre_en_o   = s_q.ctrl.run;
    assign pre_clr_o  = ctl_wr;
    assign prescale_o = s_q.ctrl.prescale;
    assign pwm_o      = s_q.pwm && s_q.ctrl.out_en && (s_q.ctrl.mode == MODE_PWM);
    assign irq_rise_o = s_q.irq_r;
    assign irq_fall_o = s_q.irq_f;

    p_gate_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.ctrl.gate_en && gate_lvl_i && !ctl_wr &&
         (s_q.ctrl.mode == MODE_PWM || s_q.ctrl.mode == MODE_TMR)) |=> $stable(s_q.cnt));

    p_cnt_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.cnt != $past(s_q.cnt)) |-> (s_q.cnt == $past(s_q.cnt) + CNT_W'(1) || s_q.cnt == '0));

    p_shadow_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.ctrl.mode != MODE_CAP && !ctl_wr) |=> ($stable(s_q.fall_a) || s_q.cnt == '0));

    p_single_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.irq_f && s_q.ctrl.single && s_q.ctrl.mode != MODE_CAP) |-> !s_q.ctrl.run);

    p_rd_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.ctrl.mode == MODE_CAP && cap_rd && !ctl_wr) |=> !s_q.ctrl.run);

endmodule

// File: rtl/pwm_cap_timer.sv
module pwm_cap_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [CNT_W-1:0]  rd_data_o,
    input  logic              gate_i,
    input  logic              cap_i,
    output logic              pwm_o,
    output logic              irq_rise_o,
    output logic              irq_fall_o
);

    logic             gate_lvl, evt_rise, evt_fall;
    logic             cap_lvl, cap_rise, cap_fall;
    logic             tick, pre_en, pre_clr;
    logic [PRE_W-1:0] prescale;

    tmr_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk_i (clk_i), .rst_ni(rst_ni), .d_i(gate_i),
        .lvl_o (gate_lvl), .rise_o(evt_rise), .fall_o(evt_fall)
    );

    tmr_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
        .clk_i (clk_i), .rst_ni(rst_ni), .d_i(cap_i),
        .lvl_o (cap_lvl), .rise_o(cap_rise), .fall_o(cap_fall)
    );

    tmr_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk_i (clk_i), .rst_ni(rst_ni), .en_i(pre_en), .clr_i(pre_clr),
        .shift_i(prescale), .tick_o(tick)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .rd_en_i    (rd_en_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o),
        .tick_i     (tick),
        .gate_lvl_i (gate_lvl),
        .evt_rise_i (evt_rise),
        .evt_fall_i (evt_fall),
        .cap_rise_i (cap_rise),
        .cap_fall_i (cap_fall),
        .pre_en_o   (pre_en),
        .pre_clr_o  (pre_clr),
        .prescale_o (prescale),
        .pwm_o      (pwm_o),
        .irq_rise_o (irq_rise_o),
        .irq_fall_o (irq_fall_o)
    );

    // the capture level itself is not needed; a mid-pulse start therefore counts from the next edge
    p_cap_edge_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_rise |=> !cap_rise);

    logic unused_cap_lvl;
    assign unused_cap_lvl = cap_lvl;

endmodule

// File: tb/pwm_cap_timer_tb_top.sv
`timescale 1ns/1ps
module pwm_cap_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        gate = 1'b0;
    logic        cap = 1'b0;
    logic        pwm, irq_r, irq_f;

    always #2 clk = ~clk;

    pwm_cap_timer dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .gate_i(gate), .cap_i(cap), .pwm_o(pwm), .irq_rise_o(irq_r), .irq_fall_o(irq_f)
    );

    typedef struct {
        string tag;
        int    val;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    int   nf = 0;
    int   nr = 0;
    int   last_cyc = 0;
    bit   last_valid = 1'b0;
    bit   done = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: counts interrupt pulses and scores Fall-interrupt spacing against the queue
    always @(negedge clk) begin
        cyc++;
        if (irq_r) nr++;
        if (irq_f) begin
            nf++;
            if (last_valid && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, cyc - last_cyc, e.val);
            end
            last_cyc   = cyc;
            last_valid = 1'b1;
        end
    end

    function automatic logic [15:0] mk(input int mode, input int p, input bit single,
                                       input bit gen, input int sel, input bit oe,
                                       input bit run, input bit ire, input bit ife);
        logic [15:0] v;
        v = '0;
        v[4:0]  = p[4:0];
        v[6:5]  = mode[1:0];
        v[7]    = single;
        v[8]    = gen;
        v[10:9] = sel[1:0];
        v[11]   = oe;
        v[12]   = run;
        v[13]   = ire;
        v[14]   = ife;
        return v;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        rd_addr = a; rd_en = 1'b1;
        #0.5 v = int'(rd_data);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic run_cycles(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #0.5 if (pwm) highs++;
        end
    endtask

    task automatic arm(input string tag, input int v1, input int cnt);
        #0.5;
        last_valid = 1'b0;
        for (int i = 0; i < cnt; i++) exp_q.push_back('{tag, v1});
    endtask

    task automatic stop_timer();
        wr(2'd0, 16'h0000);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_irq_f();
        do @(negedge clk); while (!irq_f);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v, h, c1, c2, c3, f0, r0, rr, ff;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk($sformatf("R1 reset reg %0d", a), v, 0);
        end
        chk("R1 reset pwm", int'(pwm), 0);
        chk("R1 reset irq", int'(irq_r | irq_f), 0);

        // R4 / R10: continuous PWM, rise=2 fall=5, period 6
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd5);
        wr(2'd0, mk(0, 0, 0, 0, 0, 1, 1, 1, 1));
        arm("R4 period", 6, 2);
        run_cycles(4, h);
        run_cycles(12, h);
        chk("R4 pwm high samples in two periods", h, 6);
        f0 = nf; r0 = nr;
        run_cycles(24, h);
        chk("R10 fall pulses in 24 cycles", nf - f0, 4);
        chk("R10 rise pulses in 24 cycles", nr - r0, 4);
        chk("R4 scoreboard drained", exp_q.size(), 0);

        // R5: shadow Fall, written just after a Fall match
        wait_irq_f();
        wr(2'd2, 16'd9);
        rd(2'd2, v);
        chk("R5 active fall before wrap", v, 5);
        arm("R5 new period", 10, 1);
        run_cycles(30, h);
        chk("R5 scoreboard drained", exp_q.size(), 0);
        rd(2'd2, v);
        chk("R5 active fall after wrap", v, 9);

        // R11: output disabled in PWM mode
        stop_timer();
        wr(2'd2, 16'd5);
        wr(2'd0, mk(0, 0, 0, 0, 0, 0, 1, 0, 0));
        run_cycles(20, h);
        chk("R11 pwm masked by output enable", h, 0);

        // R2: prescale P=2, timer mode, fall=3 -> 16 cycles per period
        stop_timer();
        wr(2'd1, 16'd1);
        wr(2'd2, 16'd3);
        wr(2'd0, mk(2, 2, 0, 0, 0, 1, 1, 0, 1));
        arm("R2 prescaled period", 16, 2);
        run_cycles(60, h);
        chk("R2 scoreboard drained", exp_q.size(), 0);
        chk("R11 pwm low in timer mode", h, 0);

        // R6: PWM single shot, rise=2 fall=4
        stop_timer();
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd4);
        f0 = nf;
        wr(2'd0, mk(0, 0, 1, 0, 0, 1, 1, 0, 1));
        run_cycles(30, h);
        chk("R6 single fall pulses", nf - f0, 1);
        chk("R6 pwm high samples", h, 2);
        rd(2'd0, v);
        chk("R6 run bit cleared", (v >> 12) & 1, 0);
        rd(2'd3, v);
        chk("R6 count held at fall", v, 4);

        // R3: gating in timer mode
        stop_timer();
        gate = 1'b1;
        repeat (4) @(negedge clk);
        wr(2'd2, 16'd200);
        wr(2'd0, mk(2, 0, 0, 1, 0, 0, 1, 0, 0));
        run_cycles(10, h);
        rd(2'd3, v);
        chk("R3 count held while gated", v, 0);
        gate = 1'b0;
        run_cycles(10, h);
        rd(2'd3, c1);
        chk("R3 count resumes", int'(c1 > 0), 1);
        gate = 1'b1;
        run_cycles(5, h);
        rd(2'd3, c2);
        run_cycles(5, h);
        rd(2'd3, c3);
        chk("R3 count frozen again", c3, c2);

        // R7 / R8: capture two pulses, widths 7 then 4
        stop_timer();
        gate = 1'b0;
        wr(2'd0, mk(1, 0, 0, 0, 0, 0, 1, 0, 0));
        run_cycles(3, h);
        cap = 1'b1; repeat (7) @(negedge clk); cap = 1'b0;
        run_cycles(6, h);
        cap = 1'b1; repeat (4) @(negedge clk); cap = 1'b0;
        run_cycles(6, h);
        rd(2'd3, c1);
        run_cycles(3, h);
        rd(2'd3, c2);
        chk("R8 count read does not stop", int'(c2 > c1), 1);
        rd(2'd1, rr);
        rd(2'd2, ff);
        chk("R7 last pulse width", ff - rr, 4);
        rd(2'd3, c1);
        run_cycles(5, h);
        rd(2'd3, c2);
        chk("R8 counter frozen after read", c2, c1);
        rd(2'd0, v);
        chk("R8 run bit cleared", (v >> 12) & 1, 0);

        // R9: event counting on both edges, fall=6
        stop_timer();
        repeat (4) @(negedge clk);
        wr(2'd2, 16'd6);
        f0 = nf;
        wr(2'd0, mk(3, 0, 0, 0, 3, 0, 1, 0, 1));
        for (int k = 0; k < 3; k++) begin
            gate = 1'b1; repeat (5) @(negedge clk);
            gate = 1'b0; repeat (5) @(negedge clk);
        end
        run_cycles(6, h);
        chk("R9 both-edge fall pulse", nf - f0, 1);
        rd(2'd3, v);
        chk("R9 both-edge count", v, 6);

        // R9: rising edges only, falling ignored
        stop_timer();
        wr(2'd2, 16'd10);
        wr(2'd0, mk(3, 0, 0, 0, 1, 0, 1, 0, 1));
        for (int k = 0; k < 2; k++) begin
            gate = 1'b1; repeat (5) @(negedge clk);
            gate = 1'b0; repeat (5) @(negedge clk);
        end
        run_cycles(6, h);
        rd(2'd3, v);
        chk("R9 rising-only count", v, 2);

        // R10: enables cleared -> no interrupt pulses
        stop_timer();
        wr(2'd1, 16'd1);
        wr(2'd2, 16'd3);
        f0 = nf; r0 = nr;
        wr(2'd0, mk(2, 0, 0, 0, 0, 0, 1, 0, 0));
        run_cycles(20, h);
        chk("R10 masked fall irq", nf - f0, 0);
        chk("R10 masked rise irq", nr - r0, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule